// File: doc/BRIEF.md
# Staged Compare-Value Update Chain for a Three-Phase Carrier Timer

This block sits between a software register port and a centre-aligned PWM generator. Software writes new duty compares, a counter upper limit and a half-carrier value into buffer registers. The block moves those values into the active registers that the generator compares against. An active value changes only at a carrier crest or trough, so the generator never sees a value that changes partway through a half-cycle.

The duty values take two steps. A write to the last phase's duty buffer commits the whole group. On the next clock the block copies every duty buffer into a hidden holding stage. At the next crest or trough that follows, the holding stage moves into the active compares for all phases together. Software therefore updates the earlier phases first and the last phase at the end, and it writes the last phase even when that phase's value has not changed. The limit and half-carrier buffers need no commit. They move straight to their active registers at every crest and at every trough.

Top module: `cx_xfer_chain`

## Requirements
- R1: After reset, every duty buffer, holding stage and active duty equals INIT_DUTY. The limit buffer and active limit equal INIT_LIMIT, and the half-carrier buffer and active half-carrier equal INIT_HALF.
- R2: The register address map is as follows:
  - Duty buffers for phases 0..NPH-1 are at addresses 0..NPH-1.
  - The limit buffer is at NPH and the half-carrier buffer is at NPH+1.
  - Active duties are at 2^(AW-1)+p, the active limit is at 2^(AW-1)+NPH and the active half-carrier is at 2^(AW-1)+NPH+1.
  - A write to a buffer address shows on the read port from the next clock.
  - Writes to active addresses or to unmapped addresses change nothing. Unmapped addresses read as 0.
- R3: Writes to duty buffers other than the last phase never reach the active duties, whatever crest or trough events follow.
- R4: A write to the last-phase duty buffer (address NPH-1) copies all duty buffers into the holding stage on the following clock. The holding stage changes at no other time.
- R5: A crest pulse and a trough pulse each perform the holding-to-active duty transfer.
- R6: A crest or trough in the same clock as a last-phase write transfers the earlier holding contents. The newly written values wait for a later event.
- R7: At every crest or trough, the limit and half-carrier buffers are copied into their active registers, with no commit needed. The values copied are the buffer contents from before any write in that same clock. These active registers change at no other time.
- R8: Active duties change only on the clock of a crest or trough, and only when a committed group is waiting. An event on the same clock as the holding-stage load finds nothing waiting, so the group moves at the next event.
- R9: Once a group has transferred, further events transfer nothing until the next last-phase write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| crest | input | 1 | One-clock pulse at the counter peak |
| trough | input | 1 | One-clock pulse at the counter valley |
| act_duty | output | NPH*DW | Active duty compares, phase p at bits p*DW +: DW |
| act_limit | output | DW | Active counter upper limit |
| act_half | output | DW | Active half-carrier value |

## Verification
The bench builds the block with DW=8, NPH=3 and AW=4. With these values the whole 16-entry address space, including the unmapped holes on both sides of the active window, is read back after every clock of the run. Data patterns are computed arithmetically and rotate through the byte range. They are applied in four commit/event orderings: event long after the commit, event on the load clock, event on the commit clock with an older group waiting, and events repeated with no new commit. A small cycle model derived from the requirements predicts every register at every step.

// File: rtl/cx_xfer_pkg.sv
package cx_xfer_pkg;

    // Sequencer state: a holding-stage load is due, and a committed group waits for an event.
    typedef struct packed {
        logic load;
        logic pend;
    } cx_seq_t;

    function automatic logic cx_is_event(input logic pk, input logic vl);
        return pk | vl;
    endfunction

endpackage

// File: rtl/cx_buffer_bank.sv
module cx_buffer_bank #(
    parameter int DW  = 16,
    parameter int NPH = 3,
    parameter int AW  = 4,
    parameter logic [DW-1:0] INIT_DUTY  = '0,
    parameter logic [DW-1:0] INIT_LIMIT = '0,
    parameter logic [DW-1:0] INIT_HALF  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NPH*DW-1:0] duty_buf,
    output logic [DW-1:0]     lim_buf,
    output logic [DW-1:0]     half_buf,
    output logic              commit
);
    localparam int COMMIT_ADDR = NPH - 1;
    localparam int LIM_ADDR    = NPH;
    localparam int HALF_ADDR   = NPH + 1;

    typedef struct packed {
        logic [NPH-1:0][DW-1:0] duty;
        logic [DW-1:0]          lim;
        logic [DW-1:0]          half;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int p = 0; p < NPH; p++) begin
                if (wr_addr == AW'(p)) bank_d.duty[p] = wr_data;
            end
            if (wr_addr == AW'(LIM_ADDR))  bank_d.lim  = wr_data;
            if (wr_addr == AW'(HALF_ADDR)) bank_d.half = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.duty <= {NPH{INIT_DUTY}};
            bank_q.lim  <= INIT_LIMIT;
            bank_q.half <= INIT_HALF;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign duty_buf = bank_q.duty;
    assign lim_buf  = bank_q.lim;
    assign half_buf = bank_q.half;
    assign commit   = wr_en && (wr_addr == AW'(COMMIT_ADDR));

    AST_BUF_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q != $past(bank_q)) |-> $past(wr_en)); // R2

endmodule

// File: rtl/cx_sequencer.sv
module cx_sequencer
    import cx_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic evt,
    output logic load,
    output logic xfer
);
    cx_seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.load = commit;
        if (seq_q.load)  seq_d.pend = 1'b1;
        else if (evt)    seq_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign load = seq_q.load;
    assign xfer = seq_q.pend & evt;

    AST_NO_REPEAT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xfer) && !$past(load)) |-> !xfer); // R9

endmodule

// File: rtl/cx_duty_pipe.sv
module cx_duty_pipe #(
    parameter int DW = 16,
    parameter logic [DW-1:0] INIT_DUTY = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] buf_val,
    input  logic          load,
    input  logic          xfer,
    output logic [DW-1:0] act
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] act;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (load) pipe_d.hold = buf_val;
        if (xfer) pipe_d.act  = pipe_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q.hold <= INIT_DUTY;
            pipe_q.act  <= INIT_DUTY;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign act = pipe_q.act;

    AST_HOLD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.hold != $past(pipe_q.hold)) |-> $past(load)); // R4

    AST_ACT_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.act != $past(pipe_q.act)) |-> ($past(xfer) && pipe_q.act == $past(pipe_q.hold))); // R8

endmodule

// File: rtl/cx_xfer_chain.sv
module cx_xfer_chain
    import cx_xfer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NPH = 3,
    parameter int AW  = 4,
    parameter logic [DW-1:0] INIT_DUTY  = DW'(100),
    parameter logic [DW-1:0] INIT_LIMIT = DW'(220),
    parameter logic [DW-1:0] INIT_HALF  = DW'(200)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              crest,
    input  logic              trough,
    output logic [NPH*DW-1:0] act_duty,
    output logic [DW-1:0]     act_limit,
    output logic [DW-1:0]     act_half
);
    localparam int ACT_BASE   = 2 ** (AW - 1);
    localparam int LIM_ADDR   = NPH;
    localparam int HALF_ADDR  = NPH + 1;
    localparam int ALIM_ADDR  = ACT_BASE + NPH;
    localparam int AHALF_ADDR = ACT_BASE + NPH + 1;

    logic [NPH*DW-1:0] duty_buf;
    logic [DW-1:0]     lim_buf, half_buf;
    logic              commit, load, xfer, evt;

    assign evt = cx_is_event(crest, trough);

    cx_buffer_bank #(
        .DW(DW), .NPH(NPH), .AW(AW),
        .INIT_DUTY(INIT_DUTY), .INIT_LIMIT(INIT_LIMIT), .INIT_HALF(INIT_HALF)
    ) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .duty_buf(duty_buf), .lim_buf(lim_buf), .half_buf(half_buf), .commit(commit)
    );

    cx_sequencer i_seq (
        .clk(clk), .rst_n(rst_n), .commit(commit), .evt(evt), .load(load), .xfer(xfer)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        cx_duty_pipe #(.DW(DW), .INIT_DUTY(INIT_DUTY)) i_pipe (
            .clk(clk), .rst_n(rst_n),
            .buf_val(duty_buf[p*DW +: DW]),
            .load(load), .xfer(xfer),
            .act(act_duty[p*DW +: DW])
        );
    end

    // Period values: copied straight from their buffers at every carrier event.
    typedef struct packed {
        logic [DW-1:0] lim;
        logic [DW-1:0] half;
    } per_t;

    per_t per_d, per_q;

    always_comb begin
        per_d = per_q;
        if (evt) begin
            per_d.lim  = lim_buf;
            per_d.half = half_buf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q.lim  <= INIT_LIMIT;
            per_q.half <= INIT_HALF;
        end else begin
            per_q <= per_d;
        end
    end

    assign act_limit = per_q.lim;
    assign act_half  = per_q.half;

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPH; p++) begin
            if (rd_addr == AW'(p))            rd_data = duty_buf[p*DW +: DW];
            if (rd_addr == AW'(ACT_BASE + p)) rd_data = act_duty[p*DW +: DW];
        end
        if (rd_addr == AW'(LIM_ADDR))   rd_data = lim_buf;
        if (rd_addr == AW'(HALF_ADDR))  rd_data = half_buf;
        if (rd_addr == AW'(ALIM_ADDR))  rd_data = per_q.lim;
        if (rd_addr == AW'(AHALF_ADDR)) rd_data = per_q.half;
    end

    AST_PERIOD_ONLY_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != $past(per_q)) |-> $past(crest || trough)); // R7

    AST_DUTY_ONLY_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty != $past(act_duty)) |-> $past(crest || trough)); // R5

endmodule

// File: tb/test_cx_xfer_chain.sv
`timescale 1ns/10ps
module test_cx_xfer_chain;
    localparam int DW  = 8;
    localparam int NPH = 3;
    localparam int AW  = 4;
    localparam logic [DW-1:0] IDUTY = 8'h40;
    localparam logic [DW-1:0] ILIM  = 8'h90;
    localparam logic [DW-1:0] IHALF = 8'h80;
    localparam int ABASE = 2 ** (AW - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic crest = 1'b0, trough = 1'b0;
    logic [NPH*DW-1:0] act_duty;
    logic [DW-1:0] act_limit, act_half;

    always #2.5 clk = ~clk;

    cx_xfer_chain #(.DW(DW), .NPH(NPH), .AW(AW),
        .INIT_DUTY(IDUTY), .INIT_LIMIT(ILIM), .INIT_HALF(IHALF)) i_cx_xfer_chain (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .crest(crest), .trough(trough),
        .act_duty(act_duty), .act_limit(act_limit), .act_half(act_half));

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // Model: buffers 0..NPH+1, holding stage per phase, actives 0..NPH+1.
    logic [DW-1:0] m_buf [NPH+2];
    logic [DW-1:0] m_hold [NPH];
    logic [DW-1:0] m_act [NPH+2];
    logic m_load, m_pend;

    task automatic chk(input string req, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(input int a);
        if (a < NPH + 2) return m_buf[a];
        if (a >= ABASE && a < ABASE + NPH + 2) return m_act[a - ABASE];
        return '0;
    endfunction

    task automatic check_all(input string req);
        for (int p = 0; p < NPH; p++)
            chk(req, "act_duty", act_duty[p*DW +: DW], m_act[p]);
        chk(req, "act_limit", act_limit, m_act[NPH]);
        chk(req, "act_half", act_half, m_act[NPH+1]);
        for (int a = 0; a < 2 ** AW; a++) begin
            rd_addr = AW'(a);
            #0.1;
            chk(req, "rd_data", rd_data, exp_rd(a));
        end
    endtask

    // Drive one clock at the current negedge; the model follows the requirements.
    task automatic step(input string req, input logic we, input int addr, input logic [DW-1:0] data,
                        input logic ck, input logic tr);
        logic ev;
        logic [DW-1:0] ob [NPH+2];
        wr_en = we; wr_addr = AW'(addr); wr_data = data; crest = ck; trough = tr;
        @(posedge clk);
        ev = ck | tr;
        for (int i = 0; i < NPH + 2; i++) ob[i] = m_buf[i];
        if (m_pend && ev) for (int p = 0; p < NPH; p++) m_act[p] = m_hold[p];   // R5/R6
        if (m_load) for (int p = 0; p < NPH; p++) m_hold[p] = ob[p];            // R4
        m_pend = m_load ? 1'b1 : (ev ? 1'b0 : m_pend);                          // R8/R9
        if (ev) begin m_act[NPH] = ob[NPH]; m_act[NPH+1] = ob[NPH+1]; end       // R7
        m_load = we && addr == NPH - 1;
        if (we && addr < NPH + 2) m_buf[addr] = data;                           // R2
        @(negedge clk);
        wr_en = 1'b0; crest = 1'b0; trough = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, 0, '0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin : main
        logic [DW-1:0] v;
        for (int p = 0; p < NPH; p++) begin m_buf[p] = IDUTY; m_act[p] = IDUTY; m_hold[p] = IDUTY; end
        m_buf[NPH] = ILIM; m_act[NPH] = ILIM; m_buf[NPH+1] = IHALF; m_act[NPH+1] = IHALF;
        m_load = 1'b0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: every buffer address, then active and unmapped addresses ignored
        for (int a = 0; a < NPH + 2; a++) step("R2", 1'b1, a, DW'(17 * a + 3), 1'b0, 1'b0);
        for (int a = NPH + 2; a < 2 ** AW; a++) step("R2", 1'b1, a, 8'hFF, 1'b0, 1'b0);
        // R3: non-last phase writes with events do not reach the actives
        step("R3", 1'b0, 0, '0, 1'b1, 1'b0);
        step("R3", 1'b0, 0, '0, 1'b0, 1'b1);

        for (int i = 0; i < 24; i++) begin
            v = DW'(i * 37 + 5);
            step("R3", 1'b1, 0, v, 1'b0, 1'b0);
            step("R3", 1'b1, 1, DW'(v + 8'd91), 1'b0, 1'b1);
            step("R7", 1'b1, NPH, DW'(v ^ 8'h5A), 1'b0, 1'b0);
            step("R7", 1'b1, NPH + 1, DW'(v + 8'd13), 1'b0, 1'b0);
            case (i % 4)
                0: begin   // R4, R5: commit, settle, crest
                    step("R4", 1'b1, NPH - 1, DW'(v * 3), 1'b0, 1'b0);
                    idle("R4");
                    step("R5", 1'b0, 0, '0, 1'b1, 1'b0);
                end
                1: begin   // R8: trough on the load clock, then crest
                    step("R4", 1'b1, NPH - 1, DW'(v * 5), 1'b0, 1'b0);
                    step("R8", 1'b0, 0, '0, 1'b0, 1'b1);
                    step("R5", 1'b0, 0, '0, 1'b1, 1'b0);
                end
                2: begin   // R6: event coincides with a commit while an older group waits
                    step("R4", 1'b1, NPH - 1, DW'(v + 1), 1'b0, 1'b0);
                    idle("R4");
                    step("R6", 1'b1, 0, DW'(v + 8'd44), 1'b0, 1'b0);
                    step("R6", 1'b1, NPH - 1, DW'(v + 8'd66), 1'b0, 1'b1);
                    idle("R6");
                    step("R6", 1'b0, 0, '0, 1'b1, 1'b0);
                end
                default: begin   // R9: repeated events without a new commit
                    step("R4", 1'b1, NPH - 1, DW'(v ^ 8'hC3), 1'b0, 1'b0);
                    idle("R4");
                    step("R5", 1'b0, 0, '0, 1'b0, 1'b1);
                    step("R9", 1'b1, 0, DW'(~v), 1'b0, 1'b0);
                    step("R9", 1'b0, 0, '0, 1'b1, 1'b0);
                    step("R9", 1'b0, 0, '0, 1'b0, 1'b1);
                end
            endcase
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule